// File: doc/BRIEF.md
# Bi-phase IR Frame Decoder

This block rebuilds a 14-bit bi-phase remote-control frame from run-length samples. An infrared receiver front end has already measured these samples. A frame opens with a one-cycle `start` pulse that carries the number of samples to follow. The samples then arrive one byte at a time on a valid/ready handshake. In each byte, bit 7 is the line level and bits 6:0 give the run length in sample ticks.

Each run is sorted into one half-bit or two half-bits, or it ends or aborts the frame. The collected half-bits then go through a transition check and are decoded into address, command and toggle. The result is shown with a one-cycle `done`, either as valid fields or as an error. Any samples left after collection stops are still accepted and thrown away, so the count announced at `start` is always consumed.

Top module: `ir_biphase_decoder`

## Requirements
- R1: A run of 36 to 52 ticks inclusive adds one half-bit and a run of 53 to 104 ticks adds two half-bits. In both cases the half-bit value equals bit 7 of the sample.
- R2: A sample with bit 7 high and a length of 105 or more ends collection at once. Any other length outside 36..104 (including a low run of 105 or more) makes the result an error.
- R3: Before the first sample, the half-bit store already holds one half-bit of value 1, which stands for the unmeasured opening half of the first start bit.
- R4: Collection stops as soon as 28 half-bits are held. If exactly 27 are held and the newest one is 0, a 1 is appended and the frame is decoded. Samples still owed after the stop are accepted and discarded.
- R5: When collection stops with exactly 27 half-bits for any other reason, a trailing 1 is appended. Any other total than 28 (short, or 29 after a two-half run) gives an error.
- R6: Half-bits are paired in arrival order, and the first pair is the most significant bit of the 14-bit word. The pair (1,0) decodes to 1 and the pair (0,1) decodes to 0. A pair (0,0) or (1,1) makes the result an error.
- R7: The outputs of a good frame are taken from the decoded word: `cmd` = word[5:0], `sys` = word[10:6], `toggle` = word[11], `scancode` = {3'b0, sys, 2'b0, cmd}. On an error, `err` is 1 and `sys`, `cmd`, `toggle` and `scancode` are 0.
- R8: A frame announced with a count of 1 to 3 samples is not decoded. Its samples are accepted and no `done` pulse appears.
- R9: `done` is high for exactly one cycle per decoded frame. A `start` pulse that arrives while a frame is in progress is ignored.
- R10: `in_ready` is low while idle and high while samples are owed. Every announced sample is accepted, and `done` follows the sample that stopped collection by two cycles.
- R11: A synchronous reset clears all outputs and returns the block to idle with `in_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle frame start, sampled while idle |
| count | input | 8 | Number of samples in the frame, taken with `start` |
| in_valid | input | 1 | Sample byte valid |
| in_data | input | 8 | Bit 7 level, bits 6:0 run length in ticks |
| in_ready | output | 1 | Block accepts a sample this cycle |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Result is an error |
| sys | output | 5 | System address |
| cmd | output | 6 | Command |
| toggle | output | 1 | Toggle flag |
| scancode | output | 16 | Address above an 8-bit command field |

## Verification
The hardest situations to reach are the ones where collection stops in the middle of a frame while samples are still owed. One is the 27-half-bit repair when the newest half-bit is 0. Another is the overflow to 29 half-bits after a two-half run at 27. The third is an end marker early in the frame. The bench reaches these by encoding known words into run bytes itself. It then drops the final run, overwrites chosen runs with markers or bad lengths, or hand-builds run lists that land on 27 with a 1. Each such frame still declares its full count, so the drain path has to absorb the surplus before the bench moves on.

// File: rtl/ir_biphase_decoder.sv
module ir_biphase_decoder #(
  parameter int HALF_MIN    = 36,
  parameter int HALF_MAX    = 52,
  parameter int FRAME_BITS  = 14,
  parameter int CW          = 8,
  parameter int MIN_SAMPLES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] count,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          done,
  output logic          err,
  output logic [4:0]    sys,
  output logic [5:0]    cmd,
  output logic          toggle,
  output logic [15:0]   scancode
);

  localparam int NHALF    = 2 * FRAME_BITS;
  localparam int LONG_MAX = 2 * HALF_MAX;
  localparam int HW       = $clog2(NHALF + 3);

  typedef enum logic [1:0] {S_IDLE, S_COLL, S_FIN, S_DRAIN} state_t;

  state_t           state;
  logic [CW-1:0]    rem;
  logic [NHALF-1:0] hb;
  logic [HW-1:0]    hcnt;
  logic             abort;

  logic       lvl;
  logic [6:0] dur;
  logic       is_one, is_two, is_end, is_bad;
  logic [1:0] add;
  logic [HW-1:0] ncnt;
  logic       take, stop_full, stop_fix;

  assign lvl    = in_data[7];
  assign dur    = in_data[6:0];
  assign is_one = dur >= 7'(HALF_MIN) && dur <= 7'(HALF_MAX);
  assign is_two = dur >  7'(HALF_MAX) && dur <= 7'(LONG_MAX);
  assign is_end = lvl && dur > 7'(LONG_MAX);
  assign is_bad = !is_end && !is_one && !is_two;
  assign add    = is_two ? 2'd2 : (is_one ? 2'd1 : 2'd0);
  assign ncnt   = hcnt + HW'(add);

  assign in_ready  = state == S_COLL || state == S_DRAIN;
  assign take      = in_valid && in_ready;
  assign stop_full = ncnt >= HW'(NHALF);
  assign stop_fix  = ncnt == HW'(NHALF - 1) && !lvl && (is_one || is_two);

  logic [NHALF-1:0]      hbx;
  logic [FRAME_BITS-1:0] word;
  logic                  pair_bad, fin_err;

  always_comb begin
    hbx = hb;
    if (hcnt == HW'(NHALF - 1)) hbx[NHALF-1] = 1'b1;
    word = '0;
    pair_bad = 1'b0;
    for (int i = 0; i < FRAME_BITS; i++) begin
      word[FRAME_BITS-1-i] = hbx[2*i];
      if (hbx[2*i] == hbx[2*i+1]) pair_bad = 1'b1;
    end
  end

  assign fin_err = abort || pair_bad ||
                   !(hcnt == HW'(NHALF) || hcnt == HW'(NHALF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      rem      <= '0;
      hb       <= '0;
      hcnt     <= '0;
      abort    <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      sys      <= '0;
      cmd      <= '0;
      toggle   <= 1'b0;
      scancode <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start && count != '0) begin
            rem   <= count;
            hb    <= {{(NHALF-1){1'b0}}, 1'b1};
            hcnt  <= HW'(1);
            abort <= 1'b0;
            state <= (count < CW'(MIN_SAMPLES)) ? S_DRAIN : S_COLL;
          end
        end
        S_COLL: begin
          if (take) begin
            rem <= rem - 1'b1;
            if (is_end) begin
              state <= S_FIN;
            end else if (is_bad) begin
              abort <= 1'b1;
              state <= S_FIN;
            end else begin
              for (int k = 0; k < NHALF; k++) begin
                if (k == int'(hcnt))
                  hb[k] <= lvl;
                else if (k == int'(hcnt) + 1 && add == 2'd2)
                  hb[k] <= lvl;
              end
              if (stop_fix) begin
                hb[NHALF-1] <= 1'b1;
                hcnt <= ncnt + 1'b1;
              end else begin
                hcnt <= ncnt;
              end
              if (stop_full || stop_fix || rem == CW'(1))
                state <= S_FIN;
            end
          end
        end
        S_FIN: begin
          done <= 1'b1;
          err  <= fin_err;
          if (fin_err) begin
            sys      <= '0;
            cmd      <= '0;
            toggle   <= 1'b0;
            scancode <= '0;
          end else begin
            sys      <= word[10:6];
            cmd      <= word[5:0];
            toggle   <= word[11];
            scancode <= {3'b000, word[10:6], 2'b00, word[5:0]};
          end
          state <= (rem != '0) ? S_DRAIN : S_IDLE;
        end
        S_DRAIN: begin
          if (take) begin
            rem <= rem - 1'b1;
            if (rem == CW'(1)) state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ir_biphase_decoder_chk.sv
module ir_biphase_decoder_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [CW-1:0] count,
  input logic          in_valid,
  input logic [7:0]    in_data,
  input logic          in_ready,
  input logic          done,
  input logic          err,
  input logic [4:0]    sys,
  input logic [5:0]    cmd,
  input logic          toggle,
  input logic [15:0]   scancode
);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  err_fields_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (sys == '0 && cmd == '0 && !toggle && scancode == '0));

  // R7
  scancode_layout_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (scancode[15:13] == 3'b000 && scancode[7:6] == 2'b00 &&
                        scancode[12:8] == sys && scancode[5:0] == cmd));

  // R10
  done_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(in_valid && in_ready, 2));

  // R11
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!done && !in_ready && !err));

endmodule

bind ir_biphase_decoder ir_biphase_decoder_chk #(.CW(CW)) u_chk (.*);

// File: tb/tb_ir_biphase_decoder.sv
module tb_ir_biphase_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  count = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, done, err, toggle;
  logic [4:0]  sys;
  logic [5:0]  cmd;
  logic [15:0] scancode;

  ir_biphase_decoder dut (
    .clk(clk), .rst(rst), .start(start), .count(count),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .done(done), .err(err), .sys(sys), .cmd(cmd), .toggle(toggle),
    .scancode(scancode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  int npulse = 0;
  logic c_err, c_tog;
  logic [4:0] c_sys;
  logic [5:0] c_cmd;
  logic [15:0] c_sc;
  logic [7:0] fb [0:39];
  int fn = 0;

  always @(negedge clk) if (done) begin
    npulse++;
    c_err = err; c_sys = sys; c_cmd = cmd; c_tog = toggle; c_sc = scancode;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic build(input logic [13:0] w, input int st, input int lt,
                       input bit drop_last);
    logic h [0:27];
    int k, len;
    for (int i = 0; i < 14; i++) begin
      h[2*i] = w[13-i];
      h[2*i+1] = !w[13-i];
    end
    fn = 0;
    k = 1;
    while (k < 28) begin
      len = 1;
      while (k + len < 28 && h[k+len] == h[k]) len++;
      fb[fn] = {h[k], (len == 1) ? 7'(st) : 7'(lt)};
      fn++;
      k += len;
    end
    if (drop_last) fn--;
  endtask

  task automatic run(input int cnt, input bit poke);
    npulse = 0;
    @(negedge clk); start = 1'b1; count = 8'(cnt);
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < cnt; i++) begin
      in_valid = 1'b1; in_data = fb[i];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      if (poke && i == 2) begin
        in_valid = 1'b0; start = 1'b1; count = 8'd2;
        @(negedge clk); start = 1'b0;
      end
    end
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_good(input string req, input int s, input int c,
                             input int t);
    chk(npulse == 1, "R9", {req, " done pulses"}, npulse, 1);
    chk(c_err == 1'b0, req, "err", c_err, 0);
    chk(c_sys == 5'(s), req, "sys", c_sys, s);
    chk(c_cmd == 6'(c), req, "cmd", c_cmd, c);
    chk(c_tog == 1'(t), "R7", "toggle", c_tog, t);
    chk(c_sc == 16'((s << 8) | c), "R7", "scancode", c_sc, (s << 8) | c);
    chk(in_ready == 1'b0, "R10", "ready after frame", in_ready, 0);
  endtask

  task automatic expect_err(input string req);
    chk(npulse == 1, "R9", {req, " done pulses"}, npulse, 1);
    chk(c_err == 1'b1, req, "err", c_err, 1);
    chk(c_sys == 0 && c_cmd == 0 && c_sc == 0, "R7", "fields on error",
        int'(c_sc), 0);
    chk(in_ready == 1'b0, "R10", "drained", in_ready, 0);
  endtask

  task automatic t_reset();
    chk(done == 1'b0 && err == 1'b0, "R11", "done/err after reset", done, 0);
    chk(in_ready == 1'b0, "R11", "ready after reset", in_ready, 0);
    chk(scancode == '0, "R11", "scancode after reset", scancode, 0);
  endtask

  task automatic t_nominal();
    build(14'b11_0_10101_110011, 44, 88, 1'b0);
    run(fn, 1'b0);
    expect_good("R3", 21, 51, 0);
  endtask

  task automatic t_bounds();
    build(14'b11_1_01010_101010, 36, 104, 1'b0);
    run(fn, 1'b0);
    expect_good("R1", 10, 42, 1);
    build(14'b11_1_01010_101010, 52, 53, 1'b0);
    run(fn, 1'b0);
    expect_good("R1", 10, 42, 1);
  endtask

  task automatic t_repair_drain();
    build(14'b11_1_00011_000100, 44, 88, 1'b1);
    fb[fn] = {1'b1, 7'd120};
    fn++;
    fb[fn] = {1'b0, 7'd44};
    fn++;
    run(fn, 1'b0);
    expect_good("R4", 3, 4, 1);
  endtask

  task automatic t_tail_err();
    build(14'b11_0_10101_110011, 44, 88, 1'b1);
    run(fn, 1'b0);
    expect_err("R5");
  endtask

  task automatic t_overflow();
    fb[0] = {1'b0, 7'd44};
    for (int j = 0; j < 12; j++) fb[1+j] = {(j % 2 == 0), 7'd88};
    fb[13] = {1'b1, 7'd44};
    fb[14] = {1'b0, 7'd88};
    fn = 15;
    run(fn, 1'b0);
    expect_err("R5");
  endtask

  task automatic t_early_end();
    build(14'b11_0_10101_110011, 44, 88, 1'b0);
    fb[5] = {1'b1, 7'd110};
    run(fn, 1'b0);
    expect_err("R2");
  endtask

  task automatic t_bad_len();
    build(14'b11_0_10101_110011, 44, 88, 1'b0);
    fb[3] = {1'b0, 7'd20};
    run(fn, 1'b0);
    expect_err("R2");
    build(14'b11_0_10101_110011, 44, 88, 1'b0);
    fb[4] = {1'b0, 7'd110};
    run(fn, 1'b0);
    expect_err("R2");
  endtask

  task automatic t_bad_pair();
    fb[0] = {1'b0, 7'd44};
    for (int j = 0; j < 13; j++) fb[1+j] = {(j % 2 == 0), 7'd88};
    fn = 14;
    run(fn, 1'b0);
    expect_err("R6");
  endtask

  task automatic t_short();
    fb[0] = {1'b0, 7'd44}; fb[1] = {1'b1, 7'd44}; fb[2] = {1'b0, 7'd88};
    fn = 3;
    run(fn, 1'b0);
    chk(npulse == 0, "R8", "short frame done pulses", npulse, 0);
    chk(in_ready == 1'b0, "R8", "short frame drained", in_ready, 0);
  endtask

  task automatic t_busy_start();
    build(14'b11_0_10101_110011, 44, 88, 1'b0);
    run(fn, 1'b1);
    expect_good("R9", 21, 51, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_nominal();
    t_bounds();
    t_repair_drain();
    t_tail_err();
    t_overflow();
    t_early_end();
    t_bad_len();
    t_bad_pair();
    t_short();
    t_nominal();
    t_busy_start();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule